// File: doc/BRIEF.md
# Quadword Block Transfer Channel

This block is one DMA channel that copies a block of 128-bit quadwords from a memory port out onto a streaming endpoint. Software programs it through a narrow write port that carries an 8-bit register offset and a 32-bit value. It writes a source byte address and a quadword count, then sets a start bit. The channel then reads the quadwords one at a time, in ascending address order, and hands each one to the downstream stream. The final quadword is flagged with `last`.

At the end of the block the channel emits a single-cycle completion pulse and raises a level interrupt. The interrupt stays high until the channel is started again. The channel keeps no more than one memory read in flight. A start request with a count of zero completes straight away and never touches memory.

Top module: `qdma_channel`

## Requirements
- R1: A write at offset 0x10 loads the source byte address, taken from the low ADDR_W bits of the data; the next block is fetched from that address.
- R2: A write at offset 0x20 loads the block length in quadwords, taken from the low CNT_W bits of the data; a started block delivers exactly that many beats.
- R3: A write at offset 0x00 with data bit 0 set starts a block only when the channel is idle; with bit 0 clear, or while a block is running, the write has no effect.
- R4: Each quadword is fetched by one read request, and the request addresses are source, source+16, source+32 and so on, in that order.
- R5: At most one read is outstanding at a time. No new read is issued while a fetched quadword is still waiting for downstream acceptance.
- R6: Each fetched quadword appears exactly once on the stream, in fetch order. While valid is high and ready is low, data and last hold steady.
- R7: `last` is high only on the final beat of the block.
- R8: Each started block produces exactly one `done_pulse`, one cycle wide, in the cycle after the final beat is accepted.
- R9: `irq` rises in the cycle after `done_pulse` and stays high until an accepted start (which clears it) or reset.
- R10: A start with a length of zero produces the done pulse and the interrupt without any read request or stream beat.
- R11: After reset `mem_req`, `qw_valid`, `qw_last`, `done_pulse` and `irq` are all low.
- R12: Once a block completes, the channel issues no further read until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ofs | input | 8 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | One-cycle quadword read request |
| mem_addr | output | ADDR_W | Byte address of the requested quadword |
| mem_rdata | input | 128 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| qw_valid | output | 1 | Stream beat valid |
| qw_data | output | 128 | Stream beat data |
| qw_last | output | 1 | Final beat of the block |
| qw_ready | input | 1 | Downstream accepts the beat |
| done_pulse | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt level |

## Verification
The bench builds the channel with ADDR_W=32 and CNT_W=5, so the largest count of 31 quadwords runs in a few hundred cycles. The same width also makes truncation observable: a length write of 35 must give a 3-beat block. Memory latency from zero to three cycles, together with an irregular ready pattern, exposes the single-outstanding-read rule and the stream hold behaviour. The zero-length start, the start with bit 0 clear and the start during a running block cover the cases in which nothing may move.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    localparam int          QW_W       = 128;
    localparam int          QW_BYTES   = QW_W / 8;
    localparam logic [7:0]  OFS_CTRL   = 8'h00;
    localparam logic [7:0]  OFS_SRC    = 8'h10;
    localparam logic [7:0]  OFS_LEN    = 8'h20;
    localparam int          START_BIT  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SEND,
        ST_FIN
    } eng_state_e;

    typedef struct packed {
        logic [QW_W-1:0] data;
        logic            last;
    } beat_t;

    function automatic logic is_start(input logic we, input logic [7:0] ofs,
                                      input logic [31:0] wdata);
        return we && (ofs == OFS_CTRL) && wdata[START_BIT];
    endfunction

endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
    import qdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_ofs,
    input  logic [31:0]       cfg_wdata,
    output logic [ADDR_W-1:0] src_addr,
    output logic [CNT_W-1:0]  qw_count,
    output logic              start_req
);

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_addr <= '0;
            qw_count <= '0;
        end else if (cfg_we) begin
            if (cfg_ofs == OFS_SRC) src_addr <= cfg_wdata[ADDR_W-1:0];
            if (cfg_ofs == OFS_LEN) qw_count <= cfg_wdata[CNT_W-1:0];
        end
    end

    assign start_req = is_start(cfg_we, cfg_ofs, cfg_wdata);

endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
    import qdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [CNT_W-1:0]  qw_count,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    output logic              beat_load,
    output logic              beat_is_last,
    input  logic              beat_taken,
    output logic              done_pulse,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    eng_state_e        st;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_addr <= '0;
            left     <= '0;
            irq      <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start_req) begin
                    irq      <= 1'b0;
                    cur_addr <= src_addr;
                    left     <= qw_count;
                    st       <= (qw_count == '0) ? ST_FIN : ST_REQ;
                end
                ST_REQ:  st <= ST_WAIT;
                ST_WAIT: if (mem_rvalid) st <= ST_SEND;
                ST_SEND: if (beat_taken) begin
                    cur_addr <= cur_addr + STEP;
                    left     <= left - ONE;
                    st       <= (left == ONE) ? ST_FIN : ST_REQ;
                end
                ST_FIN: begin
                    irq <= 1'b1;
                    st  <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req      = (st == ST_REQ);
    assign mem_addr     = cur_addr;
    assign beat_load    = (st == ST_WAIT) && mem_rvalid;
    assign beat_is_last = (left == ONE);
    assign done_pulse   = (st == ST_FIN);

endmodule

// File: rtl/qdma_outbuf.sv
module qdma_outbuf
    import qdma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [QW_W-1:0] load_data,
    input  logic            load_last,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [QW_W-1:0] out_data,
    output logic            out_last,
    output logic            taken
);

    beat_t held;
    logic  full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (load) begin
            full <= 1'b1;
            held <= '{data: load_data, last: load_last};
        end else if (full && out_ready) begin
            full <= 1'b0;
        end
    end

    assign out_valid = full;
    assign out_data  = held.data;
    assign out_last  = full && held.last;
    assign taken     = full && out_ready;

endmodule

// File: rtl/qdma_channel.sv
module qdma_channel
    import qdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_ofs,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [127:0]      mem_rdata,
    input  logic              mem_rvalid,
    output logic              qw_valid,
    output logic [127:0]      qw_data,
    output logic              qw_last,
    input  logic              qw_ready,
    output logic              done_pulse,
    output logic              irq
);

    logic [ADDR_W-1:0] src_addr;
    logic [CNT_W-1:0]  qw_count;
    logic              start_req;
    logic              beat_load;
    logic              beat_is_last;
    logic              beat_taken;

    qdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_ofs   (cfg_ofs),
        .cfg_wdata (cfg_wdata),
        .src_addr  (src_addr),
        .qw_count  (qw_count),
        .start_req (start_req)
    );

    qdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .start_req    (start_req),
        .src_addr     (src_addr),
        .qw_count     (qw_count),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_rvalid   (mem_rvalid),
        .beat_load    (beat_load),
        .beat_is_last (beat_is_last),
        .beat_taken   (beat_taken),
        .done_pulse   (done_pulse),
        .irq          (irq)
    );

    qdma_outbuf u_outbuf (
        .clk       (clk),
        .rst       (rst),
        .load      (beat_load),
        .load_data (mem_rdata),
        .load_last (beat_is_last),
        .out_ready (qw_ready),
        .out_valid (qw_valid),
        .out_data  (qw_data),
        .out_last  (qw_last),
        .taken     (beat_taken)
    );

endmodule

// File: rtl/qdma_channel_sva.sv
module qdma_channel_sva
    import qdma_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         cfg_we,
    input logic [7:0]   cfg_ofs,
    input logic [31:0]  cfg_wdata,
    input logic         mem_req,
    input logic         qw_valid,
    input logic [127:0] qw_data,
    input logic         qw_last,
    input logic         qw_ready,
    input logic         done_pulse,
    input logic         irq
);

    logic in_flight;
    logic start_wr;

    assign start_wr = cfg_we && (cfg_ofs == OFS_CTRL) && cfg_wdata[START_BIT];

    always_ff @(posedge clk) begin
        if (rst)                      in_flight <= 1'b0;
        else if (mem_req)             in_flight <= 1'b1;
        else if (qw_valid && qw_ready) in_flight <= 1'b0;
    end

    assert_one_read_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_flight);

    assert_no_read_while_held_R5: assert property (@(posedge clk) disable iff (rst)
        qw_valid |-> !mem_req);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (qw_valid && !qw_ready) |=> (qw_valid && $stable(qw_data) && $stable(qw_last)));

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (qw_valid && qw_ready && qw_last) |=> done_pulse);

    assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> irq);

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !start_wr) |=> irq);

endmodule

bind qdma_channel qdma_channel_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_ofs    (cfg_ofs),
    .cfg_wdata  (cfg_wdata),
    .mem_req    (mem_req),
    .qw_valid   (qw_valid),
    .qw_data    (qw_data),
    .qw_last    (qw_last),
    .qw_ready   (qw_ready),
    .done_pulse (done_pulse),
    .irq        (irq)
);

// File: tb/qdma_channel_bench.sv
`timescale 1ns/1ps
module qdma_channel_bench;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_ofs = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [127:0]      mem_rdata = '0;
    logic              mem_rvalid = 1'b0;
    logic              qw_valid;
    logic [127:0]      qw_data;
    logic              qw_last;
    logic              qw_ready = 1'b0;
    logic              done_pulse;
    logic              irq;

    always #2.5 clk = ~clk;

    qdma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_qdma_channel (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .qw_valid(qw_valid), .qw_data(qw_data), .qw_last(qw_last), .qw_ready(qw_ready),
        .done_pulse(done_pulse), .irq(irq)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] pat(input logic [31:0] a);
        return {a ^ 32'hC3C3_0F0F, ~a, a + 32'h0101_0101, {a[15:0], a[31:16]}};
    endfunction

    // reference model state
    logic [127:0] exp_q[$];
    logic [31:0]  m_src = '0;
    int           m_len = 0;
    logic [31:0]  exp_addr = '0;
    bit           busy = 0;
    bit           model_irq = 0;
    bit           prev_done = 0;
    bit           outstanding = 0;
    bit           mem_pend = 0;
    int           mem_cnt = 0;
    logic [31:0]  mem_paddr = '0;
    int           lat = 0;
    int           rdy_mode = 0;
    logic [15:0]  lfsr = 16'hACE1;
    int           done_cnt = 0;
    int           beat_cnt = 0;
    int           read_cnt = 0;

    // register snoop at the active edge (inputs were driven at negedge)
    always @(posedge clk) begin
        if (!rst && cfg_we) begin
            if (cfg_ofs == 8'h10) m_src = cfg_wdata;
            if (cfg_ofs == 8'h20) m_len = int'(cfg_wdata[CNT_W-1:0]);
            if (cfg_ofs == 8'h00 && cfg_wdata[0] && !busy) begin
                busy = 1;
                model_irq = 0;
                exp_addr = m_src;
                exp_q.delete();
                for (int i = 0; i < m_len; i++) exp_q.push_back(pat(m_src + 32'(16 * i)));
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            // memory responder
            mem_rvalid = 1'b0;
            if (mem_pend) begin
                if (mem_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = pat(mem_paddr);
                    mem_pend   = 0;
                end else mem_cnt--;
            end
            if (mem_req) begin
                chk(busy, "R12 read while idle", 0, 1);
                chk(!outstanding, "R5 second read outstanding", 1, 0);
                chk(mem_addr == exp_addr, "R4 read address", mem_addr, exp_addr);
                exp_addr += 16;
                read_cnt++;
                outstanding = 1;
                mem_pend  = 1;
                mem_cnt   = lat;
                mem_paddr = mem_addr;
            end
            // downstream
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            qw_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
            if (qw_valid && qw_ready) begin
                logic [127:0] e;
                beat_cnt++;
                outstanding = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R6 unexpected beat", qw_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(qw_data == e, "R6 beat data/order", qw_data, e);
                    chk(qw_last == (exp_q.size() == 0), "R7 last flag", qw_last,
                        (exp_q.size() == 0));
                end
            end else if (qw_valid) begin
                chk(!qw_last || exp_q.size() == 1, "R7 last early", qw_last, 0);
            end
            // completion
            chk(irq == model_irq, "R9 irq level", irq, model_irq);
            if (done_pulse) begin
                chk(!prev_done, "R8 done wider than one cycle", 1, 0);
                chk(busy && exp_q.size() == 0, "R8 done before block end", exp_q.size(), 0);
                done_cnt++;
                busy = 0;
                model_irq = 1;
            end
            prev_done = done_pulse;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ofs = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_ofs = '0; cfg_wdata = '0;
    endtask

    task automatic run_block(input logic [31:0] src, input logic [31:0] len_wr,
                             input int exp_beats, input int l, input int mode,
                             input int restart_after, input string tag);
        int d0, b0, r0;
        @(posedge clk);
        lat = l; rdy_mode = mode;
        d0 = done_cnt; b0 = beat_cnt; r0 = read_cnt;
        cfg_write(8'h10, src);
        cfg_write(8'h20, len_wr);
        cfg_write(8'h00, 32'h1);
        if (restart_after > 0) begin
            repeat (restart_after) @(posedge clk);
            cfg_write(8'h00, 32'h1);
        end
        for (int i = 0; i < 3000 && done_cnt == d0; i++) @(posedge clk);
        repeat (8) @(posedge clk);
        chk(done_cnt == d0 + 1, {tag, " R8 one done per block"}, done_cnt - d0, 1);
        chk(beat_cnt - b0 == exp_beats, {tag, " R2 beat count"}, beat_cnt - b0, exp_beats);
        chk(read_cnt - r0 == exp_beats, {tag, " R4 read count"}, read_cnt - r0, exp_beats);
        chk(irq == 1'b1, {tag, " R9 irq after block"}, irq, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!mem_req && !qw_valid && !qw_last && !done_pulse && !irq, "R11 reset outputs",
            {mem_req, qw_valid, qw_last, done_pulse, irq}, 0);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        chk(!irq && !mem_req, "R11 idle after reset", {irq, mem_req}, 0);

        run_block(32'h0000_1000, 32'd4, 4, 0, 0, 0, "R1 basic");
        run_block(32'h0000_2340, 32'd5, 5, 3, 1, 0, "R5 slow mem, gated ready");
        run_block(32'h0000_0800, 32'd1, 1, 1, 1, 0, "R7 single beat");
        run_block(32'h0000_3000, 32'd0, 0, 0, 0, 0, "R10 zero length");

        begin : ignore_bit_clear
            int r0, d0;
            @(posedge clk); r0 = read_cnt; d0 = done_cnt;
            cfg_write(8'h00, 32'h2);
            repeat (20) @(posedge clk);
            chk(read_cnt == r0 && done_cnt == d0, "R3 bit0 clear ignored", read_cnt - r0, 0);
            chk(irq == 1'b1, "R9 irq held with no start", irq, 1);
        end

        run_block(32'h0000_4400, 32'd6, 6, 2, 1, 6, "R3 restart while busy");
        run_block(32'h0000_5000, 32'd35, 3, 0, 0, 0, "R2 length truncation");
        run_block(32'h0001_0000, 32'd31, 31, 0, 0, 0, "R2 max length");
        run_block(32'h0002_0000, 32'd9, 9, 2, 1, 0, "R6 backpressure");

        begin : idle_after
            int r0;
            @(posedge clk); r0 = read_cnt;
            repeat (30) @(posedge clk);
            chk(read_cnt == r0 && !qw_valid, "R12 idle after completion", read_cnt - r0, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule